// File: doc/BRIEF.md
# Hot-Plug Slot Status Registers

This block keeps hot-insert and hot-remove bookkeeping for up to 32 slots on each of several downstream buses. Firmware sees one bus at a time through a 32-bit register window. It picks the bus with a select register, then reads which slots have a new device, which slots have a pending removal request, and which slots may be removed. The device-side logic reports events through two strobes, each carrying a bus index and a slot number. A newly inserted device sets an insert flag. A removal request sets a remove flag. Both raise a one-cycle event pulse toward the interrupt logic.

Firmware retires a slot by writing the eject register. Only the lowest set bit of the written word counts. That slot's insert and remove flags are cleared, and the block issues a one-cycle eject command naming the bus and the slot. A legacy-mode strap pins the bus select to bus 0 and keeps insert flags from clearing on read.

When a machine-reset request arrives, and after a hard reset, the block runs a flush. It ejects every still-pending removal, one slot per cycle, and then reloads each bus's removable mask from the non-hotpluggable input. Register accesses are held off until the flush ends.

Top module: `hp_slot_regs`

## Requirements
- R1: A read of byte offset 0x00 returns the insert flags of the selected bus (bit n = slot n). When legacy mode is off, the read also clears those flags. When legacy mode is on, they are kept.
- R2: An unplug-request strobe sets the remove flag of its bus and slot, and `evt_o` is high for exactly the next cycle. Offset 0x04 returns the selected bus's remove flags.
- R3: A plug strobe with `plug_hot_i` high sets the slot's insert flag and pulses `evt_o` in the next cycle. A plug strobe with `plug_hot_i` low changes no flag and raises no event.
- R4: A write to offset 0x08 takes the lowest set bit of the data as the slot. It clears that slot's insert and remove flags on the selected bus, and the cycle after the write it drives `ej_valid_o` high for one cycle with `ej_bus_o` and `ej_slot_o`. Writing zero data does nothing.
- R5: A read of 0x08 returns zero. A read of 0x10 returns the select value, zero-extended. A write to 0x10 loads the select register. Offsets 0x14 and above, and any access with address bits [1:0] not zero, read as zero and write nothing.
- R6: While the select value is NBUS or larger, every read returns zero, and an eject write neither changes flags nor issues a command.
- R7: In legacy mode, a write to 0x10 sets the select register to bus 0 whatever the data.
- R8: After a `flush_req_i` pulse, the block ejects every pending remove request. It works through bus 0 upward, and within a bus from the lowest slot upward, one eject per cycle. `reg_ready_o` stays low until all buses are done.
- R9: At the end of the flush, each bus's removable mask (offset 0x0C) equals the bitwise inverse of its 32-bit field in `fixed_mask_i`, sampled during the flush.
- R10: When a plug or unplug strobe sets a flag in the same cycle that a read or an eject clears it, the flag ends up set.
- R11: A hard reset clears all flags and sets the select to 0. The flush then runs, so `reg_ready_o` is low for NBUS cycles after reset release, and `evt_o` and `ej_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| legacy_i | input | 1 | Legacy-mode strap |
| flush_req_i | input | 1 | Machine-reset request that starts a flush |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Byte offset in the window |
| reg_wdata_i | input | 32 | Write data |
| reg_ready_o | output | 1 | Access accepted this cycle (low during flush) |
| reg_rdata_o | output | 32 | Read data, same cycle as the request |
| plug_i | input | 1 | Device-present strobe |
| plug_hot_i | input | 1 | Device was hot-added (not present at power-up) |
| plug_bus_i | input | 2 | Bus of the plug strobe |
| plug_slot_i | input | 5 | Slot of the plug strobe |
| unplug_i | input | 1 | Removal-request strobe |
| unplug_bus_i | input | 2 | Bus of the removal request |
| unplug_slot_i | input | 5 | Slot of the removal request |
| fixed_mask_i | input | 128 | Non-hotpluggable slots, 32 bits per bus, bus 0 in bits 31:0 |
| evt_o | output | 1 | Event pulse |
| ej_valid_o | output | 1 | Eject command valid (one cycle) |
| ej_bus_o | output | 2 | Eject command bus |
| ej_slot_o | output | 5 | Eject command slot |

## Verification
The hardest case to reach is the reset flush with work to do. Remove requests must be pending on more than one bus, in a slot order different from the order they were raised, and the non-hotpluggable mask must change before the flush starts. The bench raises removal strobes for bus 0 slot 31, then bus 1 slot 7, then bus 1 slot 3. It also sets an insert flag on one of those slots and widens bus 1's fixed mask. It then pulses the flush request and records every eject command cycle by cycle. It checks the exact order, that `reg_ready_o` is held low, and that the flags and masks read back afterwards match. Collisions between a strobe and a clear in the same cycle are driven by hand on the same clock edge.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int SLOTS  = 32;
    localparam int SLOT_W = 5;
    // word index (byte offset / 4) of each register in the window
    localparam logic [2:0] W_INS  = 3'd0;
    localparam logic [2:0] W_REM  = 3'd1;
    localparam logic [2:0] W_EJ   = 3'd2;
    localparam logic [2:0] W_RMV  = 3'd3;
    localparam logic [2:0] W_SEL  = 3'd4;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
    parameter int W  = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/hp_rd_mux.sv
module hp_rd_mux
    import hp_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic             en_i,
    input  logic             sel_ok_i,
    input  logic [2:0]       widx_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [31:0]      ins_i,
    input  logic [31:0]      rem_i,
    input  logic [31:0]      rmv_i,
    output logic [31:0]      rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (en_i && sel_ok_i) begin
            case (widx_i)
                W_INS:   rdata_o = ins_i;
                W_REM:   rdata_o = rem_i;
                W_EJ:    rdata_o = '0;
                W_RMV:   rdata_o = rmv_i;
                W_SEL:   rdata_o = 32'(sel_i);
                default: rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_pkg::*;
#(
    parameter int NBUS    = 4,
    parameter int SEL_W   = 8,
    parameter int DEF_BUS = 0,
    localparam int BUS_W  = (NBUS > 1) ? $clog2(NBUS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    legacy_i,
    input  logic                    flush_req_i,
    input  logic                    reg_req_i,
    input  logic                    reg_we_i,
    input  logic [4:0]              reg_addr_i,
    input  logic [31:0]             reg_wdata_i,
    output logic                    reg_ready_o,
    output logic [31:0]             reg_rdata_o,
    input  logic                    plug_i,
    input  logic                    plug_hot_i,
    input  logic [BUS_W-1:0]        plug_bus_i,
    input  logic [SLOT_W-1:0]       plug_slot_i,
    input  logic                    unplug_i,
    input  logic [BUS_W-1:0]        unplug_bus_i,
    input  logic [SLOT_W-1:0]       unplug_slot_i,
    input  logic [NBUS*SLOTS-1:0]   fixed_mask_i,
    output logic                    evt_o,
    output logic                    ej_valid_o,
    output logic [BUS_W-1:0]        ej_bus_o,
    output logic [SLOT_W-1:0]       ej_slot_o
);
    typedef struct packed {
        logic [NBUS-1:0][SLOTS-1:0] ins;
        logic [NBUS-1:0][SLOTS-1:0] rem;
        logic [NBUS-1:0][SLOTS-1:0] rmv;
        logic [SEL_W-1:0]           sel;
        logic                       flush;
        logic [BUS_W-1:0]           fbus;
        logic                       evt;
        logic                       ej_v;
        logic [BUS_W-1:0]           ej_bus;
        logic [SLOT_W-1:0]          ej_slot;
    } st_t;

    st_t st_d, st_q;

    logic              acc_ok, aligned, sel_ok, rd_go, wr_go;
    logic [2:0]        widx;
    logic [BUS_W-1:0]  sbus;
    logic              wr_found, fl_found;
    logic [SLOT_W-1:0] wr_slot, fl_slot;

    assign acc_ok  = reg_req_i && !st_q.flush;
    assign aligned = (reg_addr_i[1:0] == 2'b00);
    assign widx    = reg_addr_i[4:2];
    assign sel_ok  = (st_q.sel < SEL_W'(NBUS));
    assign sbus    = st_q.sel[BUS_W-1:0];
    assign rd_go   = acc_ok && !reg_we_i && aligned;
    assign wr_go   = acc_ok && reg_we_i && aligned;

    hp_lowbit #(.W(SLOTS)) u_wr_low (
        .vec_i   (reg_wdata_i),
        .found_o (wr_found),
        .idx_o   (wr_slot)
    );

    hp_lowbit #(.W(SLOTS)) u_fl_low (
        .vec_i   (st_q.rem[st_q.fbus]),
        .found_o (fl_found),
        .idx_o   (fl_slot)
    );

    hp_rd_mux #(.SEL_W(SEL_W)) u_rd (
        .en_i     (rd_go),
        .sel_ok_i (sel_ok),
        .widx_i   (widx),
        .sel_i    (st_q.sel),
        .ins_i    (st_q.ins[sbus]),
        .rem_i    (st_q.rem[sbus]),
        .rmv_i    (st_q.rmv[sbus]),
        .rdata_o  (reg_rdata_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.evt  = 1'b0;
        st_d.ej_v = 1'b0;

        // clearing actions first; strobes below override them
        if (rd_go && widx == W_INS && sel_ok && !legacy_i)
            st_d.ins[sbus] = '0;

        if (wr_go && widx == W_SEL)
            st_d.sel = legacy_i ? SEL_W'(DEF_BUS) : reg_wdata_i[SEL_W-1:0];

        if (wr_go && widx == W_EJ && sel_ok && wr_found) begin
            st_d.ins[sbus][wr_slot] = 1'b0;
            st_d.rem[sbus][wr_slot] = 1'b0;
            st_d.ej_v    = 1'b1;
            st_d.ej_bus  = sbus;
            st_d.ej_slot = wr_slot;
        end

        if (st_q.flush) begin
            if (fl_found) begin
                st_d.ins[st_q.fbus][fl_slot] = 1'b0;
                st_d.rem[st_q.fbus][fl_slot] = 1'b0;
                st_d.ej_v    = 1'b1;
                st_d.ej_bus  = st_q.fbus;
                st_d.ej_slot = fl_slot;
            end else begin
                st_d.rmv[st_q.fbus] = ~fixed_mask_i[st_q.fbus*SLOTS +: SLOTS];
                if (st_q.fbus == BUS_W'(NBUS - 1))
                    st_d.flush = 1'b0;
                else
                    st_d.fbus = st_q.fbus + 1'b1;
            end
        end else if (flush_req_i) begin
            st_d.flush = 1'b1;
            st_d.fbus  = '0;
        end

        if (plug_i && plug_hot_i) begin
            st_d.ins[plug_bus_i][plug_slot_i] = 1'b1;
            st_d.evt = 1'b1;
        end
        if (unplug_i) begin
            st_d.rem[unplug_bus_i][unplug_slot_i] = 1'b1;
            st_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sel   <= SEL_W'(DEF_BUS);
            st_q.flush <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_ready_o = !st_q.flush;
    assign evt_o       = st_q.evt;
    assign ej_valid_o  = st_q.ej_v;
    assign ej_bus_o    = st_q.ej_bus;
    assign ej_slot_o   = st_q.ej_slot;

    AST_HOT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        plug_i && plug_hot_i |=> evt_o); // R3
    AST_COLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        plug_i && !plug_hot_i && !unplug_i |=> !evt_o); // R3
    AST_UNPLUG_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        unplug_i |=> evt_o); // R2
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_i && !reg_we_i && (st_q.sel >= SEL_W'(NBUS)) |-> reg_rdata_o == '0); // R6
    AST_OOR_NO_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_i && reg_ready_o && reg_we_i && reg_addr_i == 5'h08
        && (st_q.sel >= SEL_W'(NBUS)) |=> !ej_valid_o); // R6
    AST_LEGACY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_i && reg_ready_o && reg_we_i && legacy_i && reg_addr_i == 5'h10
        |=> st_q.sel == SEL_W'(DEF_BUS)); // R7
    AST_FLUSH_QUIET_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_ready_o |-> reg_rdata_o == '0); // R8
endmodule

// File: tb/sim_hp_slot_regs.sv
module sim_hp_slot_regs;
    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic         rst_n = 1'b0, legacy = 1'b0, flush_req = 1'b0;
    logic         req = 1'b0, we = 1'b0;
    logic [4:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic         ready;
    logic [31:0]  rdata;
    logic         plug = 1'b0, hot = 1'b0, unplug = 1'b0;
    logic [1:0]   pbus = '0, ubus = '0;
    logic [4:0]   pslot = '0, uslot = '0;
    logic [127:0] fixed = {32'h0, 32'h0000_00F0, 32'h0000_0100, 32'h0000_0001};
    logic         evt, ejv;
    logic [1:0]   ejb;
    logic [4:0]   ejs;

    int ntest = 0, nfail = 0;

    hp_slot_regs u0 (
        .clk(clk), .rst_n(rst_n), .legacy_i(legacy), .flush_req_i(flush_req),
        .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_ready_o(ready), .reg_rdata_o(rdata),
        .plug_i(plug), .plug_hot_i(hot), .plug_bus_i(pbus), .plug_slot_i(pslot),
        .unplug_i(unplug), .unplug_bus_i(ubus), .unplug_slot_i(uslot),
        .fixed_mask_i(fixed), .evt_o(evt), .ej_valid_o(ejv), .ej_bus_o(ejb),
        .ej_slot_o(ejs)
    );

    task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [4:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1 rd = rdata;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic strobe(input logic is_unplug, input logic h, input logic [1:0] b,
                          input logic [4:0] s, input int rq, input logic exp_evt);
        @(negedge clk);
        if (is_unplug) begin unplug = 1'b1; ubus = b; uslot = s; end
        else begin plug = 1'b1; hot = h; pbus = b; pslot = s; end
        @(negedge clk);
        plug = 1'b0; unplug = 1'b0; hot = 1'b0;
        chk(rq, 32'(evt), 32'(exp_evt), "event pulse");
    endtask

    typedef struct packed {
        logic        w;
        logic [4:0]  a;
        logic [31:0] d;
        logic [31:0] rd;
        logic        ev;
        logic [1:0]  eb;
        logic [4:0]  es;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'h10, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}, // R5 sel=0
        '{1'b0, 5'h00, 32'd0,        32'h0000_0204,  1'b0, 2'd0, 5'd0,  4'd1}, // R1
        '{1'b0, 5'h00, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd1}, // R1 cleared
        '{1'b0, 5'h04, 32'd0,        32'h0000_0200,  1'b0, 2'd0, 5'd0,  4'd2}, // R2
        '{1'b0, 5'h08, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}, // R5
        '{1'b0, 5'h10, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}, // R5
        '{1'b1, 5'h08, 32'h0000_0A00,32'h0,          1'b1, 2'd0, 5'd9,  4'd4}, // R4 lowest bit
        '{1'b0, 5'h04, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd4}, // R4
        '{1'b1, 5'h10, 32'd2,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}, // R5
        '{1'b0, 5'h10, 32'd0,        32'h2,          1'b0, 2'd0, 5'd0,  4'd5}, // R5
        '{1'b0, 5'h04, 32'd0,        32'h1,          1'b0, 2'd0, 5'd0,  4'd2}, // R2
        '{1'b0, 5'h0C, 32'd0,        32'hFFFF_FF0F,  1'b0, 2'd0, 5'd0,  4'd9}, // R9
        '{1'b1, 5'h10, 32'd5,        32'h0,          1'b0, 2'd0, 5'd0,  4'd6}, // R6
        '{1'b0, 5'h10, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd6}, // R6
        '{1'b0, 5'h04, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd6}, // R6
        '{1'b0, 5'h0C, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd6}, // R6
        '{1'b1, 5'h08, 32'd1,        32'h0,          1'b0, 2'd0, 5'd0,  4'd6}, // R6 ignored
        '{1'b1, 5'h10, 32'd2,        32'h0,          1'b0, 2'd0, 5'd0,  4'd6}, // R6
        '{1'b0, 5'h04, 32'd0,        32'h1,          1'b0, 2'd0, 5'd0,  4'd6}, // R6 still set
        '{1'b1, 5'h08, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd4}, // R4 zero data
        '{1'b0, 5'h14, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}, // R5 beyond
        '{1'b0, 5'h01, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}, // R5 unaligned
        '{1'b1, 5'h09, 32'd1,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}, // R5 unaligned write
        '{1'b0, 5'h04, 32'd0,        32'h1,          1'b0, 2'd0, 5'd0,  4'd5}, // R5
        '{1'b1, 5'h08, 32'h8000_0000,32'h0,          1'b1, 2'd2, 5'd31, 4'd4}, // R4
        '{1'b1, 5'h08, 32'h3,        32'h0,          1'b1, 2'd2, 5'd0,  4'd4}, // R4
        '{1'b0, 5'h04, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd4}, // R4
        '{1'b1, 5'h10, 32'd0,        32'h0,          1'b0, 2'd0, 5'd0,  4'd5}  // R5
    };

    initial begin
        #(20 * 20000);
        nfail++;
        ntest++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cnt;
        int nej;
        logic [6:0] ejlog [4];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: ready held low while the post-reset flush walks the buses
        cnt = 0;
        while (!ready && cnt < 50) begin
            chk(11, {30'd0, evt, ejv}, 32'd0, "no pulses after reset");
            cnt++;
            @(negedge clk);
        end
        chk(11, 32'(cnt), 32'd4, "ready-low cycles after reset");
        acc(1'b0, 5'h00, 0, rd); chk(11, rd, 32'h0, "insert after reset");
        acc(1'b0, 5'h10, 0, rd); chk(11, rd, 32'h0, "select after reset");
        acc(1'b0, 5'h0C, 0, rd); chk(9, rd, 32'hFFFF_FFFE, "mask bus0");

        strobe(1'b0, 1'b1, 2'd0, 5'd2, 3, 1'b1);  // R3 hot
        strobe(1'b0, 1'b1, 2'd0, 5'd9, 3, 1'b1);
        strobe(1'b0, 1'b0, 2'd0, 5'd4, 3, 1'b0);  // R3 cold: no flag, no event
        strobe(1'b1, 1'b0, 2'd0, 5'd9, 2, 1'b1);  // R2
        strobe(1'b1, 1'b0, 2'd2, 5'd0, 2, 1'b1);

        for (int i = 0; i < NV; i++) begin
            acc(TBL[i].w, TBL[i].a, TBL[i].d, rd);
            if (!TBL[i].w) chk(int'(TBL[i].rq), rd, TBL[i].rd, $sformatf("vec %0d rdata", i));
            chk(int'(TBL[i].rq), 32'(ejv), 32'(TBL[i].ev), $sformatf("vec %0d eject valid", i));
            if (TBL[i].ev)
                chk(int'(TBL[i].rq), {25'd0, ejb, ejs}, {25'd0, TBL[i].eb, TBL[i].es},
                    $sformatf("vec %0d eject target", i));
        end

        // R10: strobe sets win over a clearing read / eject in the same cycle
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 5'h00;
        plug = 1'b1; hot = 1'b1; pbus = 2'd0; pslot = 5'd5;
        @(negedge clk);
        req = 1'b0; plug = 1'b0; hot = 1'b0;
        acc(1'b0, 5'h00, 0, rd); chk(10, rd, 32'h20, "set beats read-clear");
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 5'h08; wdata = 32'h20;
        unplug = 1'b1; ubus = 2'd0; uslot = 5'd5;
        @(negedge clk);
        req = 1'b0; we = 1'b0; unplug = 1'b0;
        chk(10, 32'(ejv), 32'd1, "eject still issued on collision");
        acc(1'b0, 5'h04, 0, rd); chk(10, rd, 32'h20, "set beats eject-clear");
        acc(1'b1, 5'h08, 32'h20, rd);

        // R7 and legacy side of R1
        legacy = 1'b1;
        acc(1'b1, 5'h10, 32'd3, rd);
        acc(1'b0, 5'h10, 0, rd); chk(7, rd, 32'h0, "legacy select forced");
        strobe(1'b0, 1'b1, 2'd0, 5'd1, 3, 1'b1);
        acc(1'b0, 5'h00, 0, rd); chk(1, rd, 32'h2, "legacy insert read 1");
        acc(1'b0, 5'h00, 0, rd); chk(1, rd, 32'h2, "legacy insert kept");
        legacy = 1'b0;
        acc(1'b0, 5'h00, 0, rd); chk(1, rd, 32'h2, "non-legacy read");
        acc(1'b0, 5'h00, 0, rd); chk(1, rd, 32'h0, "non-legacy cleared");

        // R8 / R9: flush with pending removals on two buses
        strobe(1'b1, 1'b0, 2'd0, 5'd31, 2, 1'b1);
        strobe(1'b1, 1'b0, 2'd1, 5'd7, 2, 1'b1);
        strobe(1'b1, 1'b0, 2'd1, 5'd3, 2, 1'b1);
        strobe(1'b0, 1'b1, 2'd1, 5'd3, 3, 1'b1);
        fixed[63:32] = 32'h0000_0300;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        chk(8, 32'(ready), 32'd0, "ready low in flush");
        nej = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (ejv) begin
                if (nej < 4) ejlog[nej] = {ejb, ejs};
                nej++;
            end
        end
        chk(8, 32'(nej), 32'd3, "flush eject count");
        chk(8, 32'(ejlog[0]), {25'd0, 2'd0, 5'd31}, "flush eject 1");
        chk(8, 32'(ejlog[1]), {25'd0, 2'd1, 5'd3}, "flush eject 2");
        chk(8, 32'(ejlog[2]), {25'd0, 2'd1, 5'd7}, "flush eject 3");
        chk(8, 32'(ready), 32'd1, "ready after flush");
        acc(1'b1, 5'h10, 32'd1, rd);
        acc(1'b0, 5'h04, 0, rd); chk(8, rd, 32'h0, "bus1 removes retired");
        acc(1'b0, 5'h00, 0, rd); chk(8, rd, 32'h0, "bus1 insert retired");
        acc(1'b0, 5'h0C, 0, rd); chk(9, rd, 32'hFFFF_FCFF, "bus1 mask recaptured");

        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule